// File: doc/BRIEF.md
# Register Bitfield Operation Unit

This unit performs bitfield test, set, clear and change operations on a 32-bit data register. A field is described by a 5-bit start position and a 5-bit length. Positions count from the most significant bit: position 0 is bit 31, and the field extends toward bit 0. A field that runs past bit 0 continues at bit 31. The unit produces the modified register value, a write strobe for the register file, and the condition flags that describe the field as it was before the operation.

The field mask is built in two steps. First a base mask is formed with the requested number of ones packed against the top of the word. A five-stage rotator then moves it right by 16, 8, 4, 2 and 1 bits. Each stage is enabled by one bit of the start position.

A request is presented with a one-cycle `start` strobe. The result and flags are captured on that clock edge. `done` is high during the following cycle, and `wr_en` is high in that same cycle when the operation writes.

Top module: `regfield_unit`

## Requirements
- R1: Position p selects bit 31-p as the first bit of the field. Following bits descend toward bit 0 and wrap from bit 0 to bit 31. Example: set, position 24, length 15 on 0x11223344 gives 0xFF2233FF.
- R2: A length code of 0 means a 32-bit field covering the whole word, whatever the position.
- R3: Operation code 3'b011 (set) forces every bit of the field to 1 and leaves other bits unchanged.
- R4: Operation code 3'b010 (clear) forces every bit of the field to 0 and leaves other bits unchanged.
- R5: Operation code 3'b001 (change) inverts every bit of the field and leaves other bits unchanged. Example: position 0, length 18 on 0xFFFFFFFF gives 0x00003FFF.
- R6: Operation code 3'b000 (test) returns the input value unchanged in `result`, updates the flags, and never raises `wr_en`.
- R7: Operation codes 3'b100 to 3'b111 behave exactly like test: no write, result equal to the input, flags updated.
- R8: `flag_n` equals the first (most significant) bit of the field, taken from the input before modification.
- R9: `flag_z` is 1 exactly when every bit of the field was 0 in the input.
- R10: `flag_v` and `flag_c` are always 0.
- R11: Outputs are captured on a rising edge where `start` is 1. `done` is 1 in the next cycle only. `result` and the flags hold until the next start. Reset clears all outputs.
- R12: `wr_en` is 1 in the cycle after a start with codes 3'b001, 3'b010 or 3'b011, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for a request |
| op | input | 3 | Operation code |
| src | input | 32 | Register value before the operation |
| offset | input | 5 | Field start position, 0 = bit 31 |
| width | input | 5 | Field length, 0 = 32 |
| result | output | 32 | Register value after the operation |
| wr_en | output | 1 | Register write strobe |
| flag_n | output | 1 | Field's first bit before modification |
| flag_z | output | 1 | Field was all zero |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag, always 0 |
| done | output | 1 | Result-valid pulse |

## Verification
The hardest cases to reach are fields that wrap from bit 0 back to bit 31. They need a large position and a length that together pass 32, and only some combinations of rotator stages produce them. The vector table includes several wrapping fields, including a two-bit field that straddles bits 0 and 31. A sweep of single-bit set operations over all 32 positions exercises every combination of rotator stages. Expected values come from a bench model that walks the field bit by bit instead of rotating a mask.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

    localparam int BF_DW = 32;
    localparam int BF_OW = $clog2(BF_DW);

    localparam logic [2:0] OP_TEST = 3'b000;
    localparam logic [2:0] OP_FLIP = 3'b001;
    localparam logic [2:0] OP_ZERO = 3'b010;
    localparam logic [2:0] OP_FILL = 3'b011;

    typedef enum logic [1:0] {
        K_KEEP = 2'd0,
        K_FLIP = 2'd1,
        K_ZERO = 2'd2,
        K_FILL = 2'd3
    } bf_kind_e;

    typedef struct packed {
        logic     writes;
        bf_kind_e kind;
    } bf_ctrl_t;

    // Decode the operation code; reserved codes fall back to a read-only test.
    function automatic bf_ctrl_t decode_op(input logic [2:0] code);
        bf_ctrl_t c;
        case (code)
            OP_FLIP: c = '{writes: 1'b1, kind: K_FLIP};
            OP_ZERO: c = '{writes: 1'b1, kind: K_ZERO};
            OP_FILL: c = '{writes: 1'b1, kind: K_FILL};
            default: c = '{writes: 1'b0, kind: K_KEEP};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
    parameter int DW = 32,
    localparam int OW = $clog2(DW)
) (
    input  logic [OW-1:0] offset,
    input  logic [OW-1:0] width,
    output logic [DW-1:0] mask
);

    logic [DW-1:0] base;
    logic [DW-1:0] stage [0:OW];

    // Ones packed against the MSB; a zero length selects the whole word.
    always_comb begin
        if (width == '0)
            base = '1;
        else
            base = ~({DW{1'b1}} >> width);
    end

    assign stage[OW] = base;

    // Rotate right by 2^k when offset bit k is set, largest stage first.
    for (genvar k = OW - 1; k >= 0; k--) begin : g_rot
        localparam int SH = 1 << k;
        assign stage[k] = offset[k] ? {stage[k+1][SH-1:0], stage[k+1][DW-1:SH]}
                                    : stage[k+1];
    end

    assign mask = stage[0];

endmodule

// File: rtl/bf_apply.sv
module bf_apply
    import regfield_pkg::*;
#(
    parameter int DW = 32,
    localparam int OW = $clog2(DW)
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] mask,
    input  logic [OW-1:0] offset,
    output logic [DW-1:0] value,
    output logic          neg,
    output logic          zero,
    output logic          writes
);

    bf_ctrl_t      ctrl;
    logic [OW-1:0] lead_idx;

    assign ctrl     = decode_op(op);
    assign writes   = ctrl.writes;
    assign lead_idx = OW'(DW - 1) - offset;
    assign neg      = src[lead_idx];
    assign zero     = ~|(src & mask);

    always_comb begin
        unique case (ctrl.kind)
            K_FLIP:  value = src ^ mask;
            K_ZERO:  value = src & ~mask;
            K_FILL:  value = src | mask;
            default: value = src;
        endcase
    end

endmodule

// File: rtl/regfield_unit.sv
module regfield_unit
    import regfield_pkg::*;
#(
    parameter int DATA_W = BF_DW,
    localparam int OFS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src,
    input  logic [OFS_W-1:0]  offset,
    input  logic [OFS_W-1:0]  width,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              done
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              neg;
        logic              zero;
        logic              wr;
    } out_t;

    logic [DATA_W-1:0] mask;
    out_t              nxt;
    out_t              cur;
    logic              done_q;

    bf_mask_gen #(.DW(DATA_W)) u_mask (
        .offset (offset),
        .width  (width),
        .mask   (mask)
    );

    bf_apply #(.DW(DATA_W)) u_apply (
        .op     (op),
        .src    (src),
        .mask   (mask),
        .offset (offset),
        .value  (nxt.value),
        .neg    (nxt.neg),
        .zero   (nxt.zero),
        .writes (nxt.wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start)
                cur <= nxt;
            else
                cur.wr <= 1'b0;
        end
    end

    assign result = cur.value;
    assign flag_n = cur.neg;
    assign flag_z = cur.zero;
    assign wr_en  = cur.wr;
    assign done   = done_q;
    assign flag_v = 1'b0;
    assign flag_c = 1'b0;

endmodule

// File: rtl/regfield_chk.sv
module regfield_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [2:0]    op,
    input logic [DW-1:0] src,
    input logic [DW-1:0] result,
    input logic          wr_en,
    input logic          flag_n,
    input logic          flag_z,
    input logic          done
);

    // R11
    done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

    // R12
    wr_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);

    // R6
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'b000) |=> !wr_en);

    // R6
    test_keeps_value_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op == 3'b000) |=> (result == $past(src)));

    // R9
    zero_field_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_z) |-> !flag_n);

endmodule

bind regfield_unit regfield_chk #(.DW(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .src    (src),
    .result (result),
    .wr_en  (wr_en),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .done   (done)
);

// File: tb/tb_regfield_unit.sv
module tb_regfield_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src = '0;
    logic [4:0]  offset = '0;
    logic [4:0]  width = '0;
    logic [31:0] result;
    logic        wr_en, flag_n, flag_z, flag_v, flag_c, done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    regfield_unit dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .src(src),
        .offset(offset), .width(width), .result(result), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .done(done)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] src;
        logic [4:0]  off;
        logic [4:0]  wid;
        logic [31:0] exp;
        logic        n;
        logic        z;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 32'h11223344, 5'd24, 5'd15, 32'hFF2233FF, 1'b0, 1'b0},
        '{3'd1, 32'hFFFFFFFF, 5'd0,  5'd18, 32'h00003FFF, 1'b1, 1'b0},
        '{3'd0, 32'hFFFFFFFF, 5'd0,  5'd18, 32'hFFFFFFFF, 1'b1, 1'b0},
        '{3'd2, 32'hFFFFFFFF, 5'd8,  5'd8,  32'hFF00FFFF, 1'b1, 1'b0},
        '{3'd3, 32'h00000000, 5'd0,  5'd0,  32'hFFFFFFFF, 1'b0, 1'b1},
        '{3'd2, 32'h12345678, 5'd0,  5'd0,  32'h00000000, 1'b0, 1'b0},
        '{3'd1, 32'h0000000F, 5'd28, 5'd8,  32'hF0000000, 1'b1, 1'b0},
        '{3'd0, 32'h00000000, 5'd31, 5'd1,  32'h00000000, 1'b0, 1'b1},
        '{3'd5, 32'hAAAAAAAA, 5'd4,  5'd4,  32'hAAAAAAAA, 1'b1, 1'b0},
        '{3'd3, 32'h80000000, 5'd31, 5'd2,  32'h80000001, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // Bench model: walks the field one bit at a time.
    task automatic model(input logic [2:0] o, input logic [31:0] s,
                         input int off, input int wid,
                         output logic [31:0] r, output logic n, output logic z);
        int w;
        w = (wid == 0) ? 32 : wid;
        r = s;
        z = 1'b1;
        n = s[31 - off];
        for (int i = 0; i < w; i++) begin
            int idx;
            idx = 31 - ((off + i) % 32);
            if (s[idx]) z = 1'b0;
            case (o)
                3'd1: r[idx] = ~s[idx];
                3'd2: r[idx] = 1'b0;
                3'd3: r[idx] = 1'b1;
                default: ;
            endcase
        end
    endtask

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd0: return "R6";
            3'd1: return "R5";
            3'd2: return "R4";
            3'd3: return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic issue(input logic [2:0] o, input logic [31:0] s,
                         input logic [4:0] off, input logic [4:0] wid);
        @(negedge clk);
        op = o; src = s; offset = off; width = wid; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_outputs(input string tag, input logic [2:0] o,
                                 input logic [31:0] er, input logic en,
                                 input logic ez);
        logic ew;
        ew = (o == 3'd1 || o == 3'd2 || o == 3'd3);
        chk(result == er, tag, "result", result, er);
        chk(wr_en == ew, (ew ? "R12" : "R6"), "wr_en", 32'(wr_en), 32'(ew));
        chk(flag_n == en, "R8", "flag_n", 32'(flag_n), 32'(en));
        chk(flag_z == ez, "R9", "flag_z", 32'(flag_z), 32'(ez));
        chk(done == 1'b1, "R11", "done", 32'(done), 32'd1);
        chk(flag_v == 1'b0 && flag_c == 1'b0, "R10", "v/c",
            32'({flag_v, flag_c}), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] mr;
        logic mn, mz;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(result == 32'd0, "R11", "reset result", result, 32'd0);
        chk(done == 1'b0 && wr_en == 1'b0, "R11", "reset done/wr",
            32'({done, wr_en}), 32'd0);
        chk(flag_n == 1'b0 && flag_z == 1'b0, "R11", "reset flags",
            32'({flag_n, flag_z}), 32'd0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].op, VECS[k].src, VECS[k].off, VECS[k].wid);
            check_outputs(op_tag(VECS[k].op), VECS[k].op, VECS[k].exp,
                          VECS[k].n, VECS[k].z);
            model(VECS[k].op, VECS[k].src, int'(VECS[k].off), int'(VECS[k].wid),
                  mr, mn, mz);
            chk(mr == VECS[k].exp && mn == VECS[k].n && mz == VECS[k].z,
                "R1", "table vs model", mr, VECS[k].exp);
        end

        // R1: single-bit set at every position reaches every rotator combination
        for (int p = 0; p < 32; p++) begin
            issue(3'd3, 32'd0, 5'(p), 5'd1);
            chk(result == (32'h80000000 >> p), "R1", "single bit position",
                result, 32'h80000000 >> p);
        end

        // R1: wrapping change fields checked against the model
        for (int p = 20; p < 32; p += 3) begin
            issue(3'd1, 32'h5A5AC3C3, 5'(p), 5'd17);
            model(3'd1, 32'h5A5AC3C3, p, 17, mr, mn, mz);
            chk(result == mr, "R1", "wrap change", result, mr);
            chk(flag_n == mn && flag_z == mz, "R8", "wrap flags",
                32'({flag_n, flag_z}), 32'({mn, mz}));
        end

        // R2: length code 0 covers the whole word regardless of position
        issue(3'd1, 32'h0F0F0F0F, 5'd0, 5'd0);
        chk(result == 32'hF0F0F0F0, "R2", "full word offset 0", result, 32'hF0F0F0F0);
        issue(3'd1, 32'h0F0F0F0F, 5'd13, 5'd0);
        chk(result == 32'hF0F0F0F0, "R2", "full word offset 13", result, 32'hF0F0F0F0);

        // R7: highest reserved code acts as test
        issue(3'd7, 32'hDEADBEEF, 5'd4, 5'd8);
        chk(result == 32'hDEADBEEF, "R7", "reserved result", result, 32'hDEADBEEF);
        chk(wr_en == 1'b0, "R7", "reserved wr_en", 32'(wr_en), 32'd0);
        chk(flag_z == 1'b0 && flag_n == 1'b1, "R7", "reserved flags",
            32'({flag_n, flag_z}), 32'b10);

        // R11/R12: outputs hold and strobes drop without a start
        issue(3'd2, 32'hFFFFFFFF, 5'd16, 5'd16);
        held = result;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R11", "done after idle", 32'(done), 32'd0);
        chk(wr_en == 1'b0, "R12", "wr_en after idle", 32'(wr_en), 32'd0);
        chk(result == held && held == 32'hFFFF0000, "R11", "result held",
            result, 32'hFFFF0000);

        // R11: back-to-back starts
        @(negedge clk);
        op = 3'd3; src = 32'h00000000; offset = 5'd0; width = 5'd4; start = 1'b1;
        @(negedge clk);
        chk(result == 32'hF0000000 && done, "R11", "first of pair",
            result, 32'hF0000000);
        op = 3'd2; src = 32'hFFFFFFFF; offset = 5'd28; width = 5'd4;
        @(negedge clk);
        start = 1'b0;
        chk(result == 32'hFFFFFFF0 && done && wr_en, "R11", "second of pair",
            result, 32'hFFFFFFF0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "pair done drops", 32'(done), 32'd0);

        // R11: reset clears a held result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(result == 32'd0 && !done && !wr_en, "R11", "reset clears",
            result, 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule